// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the processor state changes that take place when an exception or an external interrupt is accepted. When the core raises a one-cycle strobe, the block looks at several inputs: the pending exception code, the pending interrupt request with its priority level and vector, and the current status register, program counter, stack register, vector base and delay-slot flags. It then decides whether an event is taken and which one.

If an event is taken, the block saves status, PC and stack register. It sets the blocking, privileged and bank bits in the status register. It corrects the saved PC for delay slots and for the trap instruction, records the event code, and produces the handler address.

All state updates happen on the clock edge that samples the strobe. A done pulse, together with a one-cycle flag saying which kind of event was taken, appears in the cycle that follows. A strobe that finds nothing acceptable still produces done. In that case every saved and updated register keeps its value.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending exception (code not all ones, 0xFFF) is taken in preference to an interrupt pending in the same strobe; the interrupt-event register is then left unchanged.
- R2: With the blocking bit (status bit 28) set, any exception other than code 0x1E0 is recorded and vectored as code 0x000; code 0x1E0 keeps its own code.
- R3: With the blocking bit set, an interrupt is ignored unless the wake-from-halt input is high.
- R4: An interrupt is accepted only when its level is strictly greater than the status mask field (bits 7:4); a strobe with no accepted event changes no saved or updated register.
- R5: On an accepted event the saved status gets the incoming status, the saved stack register gets the incoming register 15, and the new status has bits 28 (block), 30 (privileged) and 29 (bank) set.
- R6: Delay-slot flags are bit 0 (slot), bit 1 (conditional slot), bit 2 (condition true), bit 3 (clear-all). If bit 0 or 1 is set, the saved PC is the incoming PC minus 2 and bits 2:0 are cleared; if bit 3 is set all flags are cleared; otherwise the flags pass unchanged.
- R7: Exception codes 0x000, 0x020 and 0x140 clear the FPU-disable bit (status bit 15), set the mask field to 0xF and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to vector base + 0x400; every other exception jumps to vector base + 0x100.
- R9: The trap code 0x160 adds 2 to the saved PC, after any delay-slot correction.
- R10: A taken exception loads its (possibly forced) code into the exception-event register; a taken interrupt loads its vector into the interrupt-event register and jumps to vector base + 0x600.
- R11: Done is high exactly in the cycle after a strobe, with at most one of the taken flags; outputs change only on a strobe edge.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe: evaluate and apply entry |
| exc_code | input | 12 | Pending exception code, 0xFFF when none |
| irq_req | input | 1 | Interrupt pending |
| irq_level | input | 4 | Priority level of pending interrupt |
| irq_vector | input | 12 | Vector code of pending interrupt |
| wake_halt | input | 1 | Core is waking from a halt |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current PC |
| r15_in | input | 32 | Current stack register (general register 15) |
| vbr_in | input | 32 | Vector base |
| ds_in | input | 4 | Delay-slot flags |
| ssr | output | 32 | Saved status |
| spc | output | 32 | Saved PC |
| sgr | output | 32 | Saved stack register |
| sr_out | output | 32 | Updated status register |
| expevt | output | 12 | Exception-event register |
| intevt | output | 12 | Interrupt-event register |
| pc_out | output | 32 | Handler address |
| ds_out | output | 4 | Updated delay-slot flags |
| taken_exc | output | 1 | Pulse: an exception was taken |
| taken_irq | output | 1 | Pulse: an interrupt was taken |
| done | output | 1 | Pulse one cycle after start |

## Verification
The vector table exercises each vector class: a general exception, both TLB-miss codes, the reset-class codes, the trap, and an accepted interrupt. It also drives an exception and an interrupt together, which separates exception-first arbitration from the reverse. Interrupts at a level equal to the mask, and at the maximum mask, show the strict comparison. Blocked cases with and without wake-from-halt, and an exception under blocking with 0x1E0 versus another code, show the forced reset path. Delay-slot flag combinations, including a trap inside a slot, show how the PC correction and the flag clearing compose.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int XLEN   = 32;
  localparam int CODE_W = 12;
  localparam int LVL_W  = 4;
  localparam int DS_W   = 4;

  localparam int SR_BL_BIT = 28;
  localparam int SR_RB_BIT = 29;
  localparam int SR_MD_BIT = 30;
  localparam int SR_FD_BIT = 15;
  localparam int SR_IM_LO  = 4;

  localparam logic [CODE_W-1:0] CODE_NONE    = '1;
  localparam logic [CODE_W-1:0] CODE_RESET   = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MANRST  = 12'h020;
  localparam logic [CODE_W-1:0] CODE_MULTI   = 12'h140;
  localparam logic [CODE_W-1:0] CODE_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP    = 12'h160;
  localparam logic [CODE_W-1:0] CODE_UNBLOCK = 12'h1E0;

  localparam logic [XLEN-1:0] RESET_TARGET = 32'hA000_0000;
  localparam logic [XLEN-1:0] OFS_GENERAL  = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_TLBMISS  = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFS_IRQ      = 32'h0000_0600;

  function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
    return (c == CODE_RESET) || (c == CODE_MANRST) || (c == CODE_MULTI);
  endfunction

  function automatic logic is_tlb_miss(input logic [CODE_W-1:0] c);
    return (c == CODE_MISS_RD) || (c == CODE_MISS_WR);
  endfunction

  function automatic logic in_delay_slot(input logic [DS_W-1:0] ds);
    return ds[0] | ds[1];
  endfunction

  // Signed correction applied to the saved PC: -2 for a slot, +2 for a trap.
  function automatic logic [XLEN-1:0] saved_pc(input logic [XLEN-1:0] pc,
                                               input logic slot,
                                               input logic trap);
    logic [XLEN-1:0] adj;
    case ({slot, trap})
      2'b10:   adj = '1 - 32'd1;   // two's complement of 2
      2'b01:   adj = 32'd2;
      default: adj = '0;
    endcase
    return pc + adj;
  endfunction

  function automatic logic [DS_W-1:0] next_flags(input logic [DS_W-1:0] ds);
    logic [DS_W-1:0] r;
    r = ds;
    if (in_delay_slot(ds)) r[2:0] = 3'b000;
    if (ds[3]) r = '0;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] entry_sr(input logic [XLEN-1:0] sr,
                                               input logic rst_class);
    logic [XLEN-1:0] r;
    r = sr;
    r[SR_BL_BIT] = 1'b1;
    r[SR_MD_BIT] = 1'b1;
    r[SR_RB_BIT] = 1'b1;
    if (rst_class) begin
      r[SR_FD_BIT] = 1'b0;
      r[SR_IM_LO +: LVL_W] = '1;
    end
    return r;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              wake_halt,
  input  logic [XLEN-1:0]   sr_in,
  output logic              take_exc,
  output logic              take_irq,
  output logic [CODE_W-1:0] eff_code
);

  logic exc_pending;
  logic blocked;
  logic level_ok;

  assign exc_pending = (exc_code != CODE_NONE);
  assign blocked     = sr_in[SR_BL_BIT];
  assign level_ok    = irq_level > sr_in[SR_IM_LO +: LVL_W];

  always_comb begin
    eff_code = exc_code;
    if (blocked && exc_code != CODE_UNBLOCK) eff_code = CODE_RESET;
  end

  assign take_exc = exc_pending;
  assign take_irq = irq_req && !exc_pending && level_ok && (!blocked || wake_halt);

  always_comb begin
    assert_exclusive_R1: assert (!(take_exc && take_irq))
      else $error("exception and interrupt both selected");
  end

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
(
  input  logic              take_exc,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [DS_W-1:0]   ds_in,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_spc,
  output logic [DS_W-1:0]   new_ds
);

  logic rst_class;
  logic trap;
  logic slot;

  assign rst_class = take_exc && is_reset_class(eff_code);
  assign trap      = take_exc && (eff_code == CODE_TRAP);
  assign slot      = in_delay_slot(ds_in);

  always_comb begin
    if (!take_exc)                 new_pc = vbr_in + OFS_IRQ;
    else if (rst_class)            new_pc = RESET_TARGET;
    else if (is_tlb_miss(eff_code)) new_pc = vbr_in + OFS_TLBMISS;
    else                           new_pc = vbr_in + OFS_GENERAL;
  end

  assign new_sr  = entry_sr(sr_in, rst_class);
  assign new_spc = saved_pc(pc_in, slot, trap);
  assign new_ds  = next_flags(ds_in);

  always_comb begin
    assert_reset_sr_R7: assert (!rst_class || (new_sr[SR_IM_LO +: LVL_W] == '1 && !new_sr[SR_FD_BIT]))
      else $error("reset-class entry left mask or FPU bit wrong");
  end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take_exc,
  input  logic              take_irq,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [CODE_W-1:0] irq_vector,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   new_pc,
  input  logic [XLEN-1:0]   new_sr,
  input  logic [XLEN-1:0]   new_spc,
  input  logic [DS_W-1:0]   new_ds,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   sr_out,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic [XLEN-1:0]   pc_out,
  output logic [DS_W-1:0]   ds_out,
  output logic              taken_exc,
  output logic              taken_irq,
  output logic              done
);

  logic fire_exc;
  logic fire_irq;
  logic fire_any;

  assign fire_exc = start && take_exc;
  assign fire_irq = start && take_irq;
  assign fire_any = fire_exc || fire_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ssr       <= '0;
      spc       <= '0;
      sgr       <= '0;
      sr_out    <= '0;
      expevt    <= '0;
      intevt    <= '0;
      pc_out    <= '0;
      ds_out    <= '0;
      taken_exc <= 1'b0;
      taken_irq <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= start;
      taken_exc <= fire_exc;
      taken_irq <= fire_irq;
      if (fire_any) begin
        ssr    <= sr_in;
        spc    <= new_spc;
        sgr    <= r15_in;
        sr_out <= new_sr;
        pc_out <= new_pc;
        ds_out <= new_ds;
      end
      if (fire_exc) expevt <= eff_code;
      if (fire_irq) intevt <= irq_vector;
    end
  end

  assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_stray_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken_exc, taken_irq}));
  assert_entry_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_exc || taken_irq) |-> (sr_out[SR_BL_BIT] && sr_out[SR_MD_BIT] && sr_out[SR_RB_BIT]));
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !take_exc && !take_irq) |=> ($stable(pc_out) && $stable(spc) && $stable(sr_out)));
  assert_intevt_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    taken_exc |-> $stable(intevt));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [CODE_W-1:0] irq_vector,
  input  logic              wake_halt,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [DS_W-1:0]   ds_in,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   sr_out,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic [XLEN-1:0]   pc_out,
  output logic [DS_W-1:0]   ds_out,
  output logic              taken_exc,
  output logic              taken_irq,
  output logic              done
);

  logic              take_exc_w;
  logic              take_irq_w;
  logic [CODE_W-1:0] eff_code_w;
  logic [XLEN-1:0]   new_pc_w;
  logic [XLEN-1:0]   new_sr_w;
  logic [XLEN-1:0]   new_spc_w;
  logic [DS_W-1:0]   new_ds_w;

  exc_arbiter u_arb (
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .wake_halt (wake_halt),
    .sr_in     (sr_in),
    .take_exc  (take_exc_w),
    .take_irq  (take_irq_w),
    .eff_code  (eff_code_w)
  );

  exc_target u_tgt (
    .take_exc (take_exc_w),
    .eff_code (eff_code_w),
    .sr_in    (sr_in),
    .pc_in    (pc_in),
    .vbr_in   (vbr_in),
    .ds_in    (ds_in),
    .new_pc   (new_pc_w),
    .new_sr   (new_sr_w),
    .new_spc  (new_spc_w),
    .new_ds   (new_ds_w)
  );

  exc_state_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .take_exc   (take_exc_w),
    .take_irq   (take_irq_w),
    .eff_code   (eff_code_w),
    .irq_vector (irq_vector),
    .sr_in      (sr_in),
    .r15_in     (r15_in),
    .new_pc     (new_pc_w),
    .new_sr     (new_sr_w),
    .new_spc    (new_spc_w),
    .new_ds     (new_ds_w),
    .ssr        (ssr),
    .spc        (spc),
    .sgr        (sgr),
    .sr_out     (sr_out),
    .expevt     (expevt),
    .intevt     (intevt),
    .pc_out     (pc_out),
    .ds_out     (ds_out),
    .taken_exc  (taken_exc),
    .taken_irq  (taken_irq),
    .done       (done)
  );

  assert_irq_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    taken_irq |-> (pc_out == $past(vbr_in) + 32'h600));
  assert_forced_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_exc && $past(sr_in[SR_BL_BIT]) && $past(exc_code) != CODE_UNBLOCK)
      |-> (expevt == CODE_RESET && pc_out == RESET_TARGET));
  assert_blocked_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sr_in[SR_BL_BIT] && !wake_halt) |=> !taken_irq);
  assert_trap_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_exc && expevt == CODE_TRAP && $past(ds_in[1:0]) == 2'b00)
      |-> (spc == $past(pc_in) + 32'd2));

endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

  typedef struct packed {
    logic [11:0] exc;
    logic        irq;
    logic [3:0]  lvl;
    logic [11:0] ivec;
    logic        wake;
    logic [31:0] sr;
    logic [31:0] pc;
    logic [3:0]  ds;
    logic [31:0] e_pc;
    logic [31:0] e_spc;
    logic [31:0] e_sr;
    logic [3:0]  e_ds;
    logic [1:0]  kind;   // 0 none, 1 exception, 2 interrupt
    logic [11:0] e_evt;
  } vec_t;

  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] R15 = 32'h0CFF_FF00;
  localparam int NV = 18;

  localparam vec_t VECS [NV] = '{
    '{12'h0E0,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h0, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd1,12'h0E0}, // R8 general
    '{12'h040,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h0, 32'h8C00_0400,32'h0C00_1000,32'h7000_0030,4'h0,2'd1,12'h040}, // R8 miss read
    '{12'h060,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h1, 32'h8C00_0400,32'h0C00_0FFE,32'h7000_0030,4'h0,2'd1,12'h060}, // R8 R6
    '{12'h160,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h0, 32'h8C00_0100,32'h0C00_1002,32'h7000_0030,4'h0,2'd1,12'h160}, // R9
    '{12'h020,1'b0,4'h0,12'h000,1'b0,32'h0000_8030,32'h0C00_1000,4'h0, 32'hA000_0000,32'h0C00_1000,32'h7000_00F0,4'h0,2'd1,12'h020}, // R7
    '{12'h140,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h0, 32'hA000_0000,32'h0C00_1000,32'h7000_00F0,4'h0,2'd1,12'h140}, // R7
    '{12'h0E0,1'b0,4'h0,12'h000,1'b0,32'h1000_0030,32'h0C00_1000,4'h0, 32'hA000_0000,32'h0C00_1000,32'h7000_00F0,4'h0,2'd1,12'h000}, // R2 forced
    '{12'h1E0,1'b0,4'h0,12'h000,1'b0,32'h1000_0030,32'h0C00_1000,4'h0, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd1,12'h1E0}, // R2 kept
    '{12'hFFF,1'b1,4'h5,12'h3A0,1'b0,32'h0000_0030,32'h0C00_1000,4'h0, 32'h8C00_0600,32'h0C00_1000,32'h7000_0030,4'h0,2'd2,12'h3A0}, // R10
    '{12'hFFF,1'b1,4'h3,12'h3C0,1'b0,32'h0000_0030,32'h0C00_2000,4'h0, 32'h8C00_0600,32'h0C00_1000,32'h7000_0030,4'h0,2'd0,12'h000}, // R4 equal
    '{12'h0A0,1'b1,4'h9,12'h400,1'b0,32'h0000_0030,32'h0C00_1000,4'h0, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd1,12'h0A0}, // R1
    '{12'hFFF,1'b1,4'h9,12'h5C0,1'b0,32'h1000_0030,32'h0C00_2000,4'h0, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd0,12'h000}, // R3 blocked
    '{12'hFFF,1'b1,4'h9,12'h5C0,1'b1,32'h1000_0030,32'h0C00_1000,4'h0, 32'h8C00_0600,32'h0C00_1000,32'h7000_0030,4'h0,2'd2,12'h5C0}, // R3 wake
    '{12'h0E0,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'hA, 32'h8C00_0100,32'h0C00_0FFE,32'h7000_0030,4'h0,2'd1,12'h0E0}, // R6
    '{12'h0E0,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h4, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h4,2'd1,12'h0E0}, // R6 pass
    '{12'h160,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_1000,4'h1, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd1,12'h160}, // R9 R6
    '{12'hFFF,1'b0,4'h0,12'h000,1'b0,32'h0000_0030,32'h0C00_3000,4'h2, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd0,12'h000}, // R4 none
    '{12'hFFF,1'b1,4'hF,12'h600,1'b0,32'h0000_00F0,32'h0C00_3000,4'h0, 32'h8C00_0100,32'h0C00_1000,32'h7000_0030,4'h0,2'd0,12'h000}  // R4 max mask
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] exc_code = 12'hFFF;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_level = 4'h0;
  logic [11:0] irq_vector = 12'h000;
  logic        wake_halt = 1'b0;
  logic [31:0] sr_in = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] r15_in = R15;
  logic [31:0] vbr_in = VBR;
  logic [3:0]  ds_in = '0;
  logic [31:0] ssr, spc, sgr, sr_out, pc_out;
  logic [11:0] expevt, intevt;
  logic [3:0]  ds_out;
  logic        taken_exc, taken_irq, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .exc_code(exc_code),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .wake_halt(wake_halt), .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in),
    .vbr_in(vbr_in), .ds_in(ds_in), .ssr(ssr), .spc(spc), .sgr(sgr),
    .sr_out(sr_out), .expevt(expevt), .intevt(intevt), .pc_out(pc_out),
    .ds_out(ds_out), .taken_exc(taken_exc), .taken_irq(taken_irq), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input vec_t v);
    @(negedge clk);
    exc_code = v.exc; irq_req = v.irq; irq_level = v.lvl; irq_vector = v.ivec;
    wake_halt = v.wake; sr_in = v.sr; pc_in = v.pc; ds_in = v.ds;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    logic [31:0] last_ssr;
    logic [11:0] last_exp, last_int;
    last_ssr = '0; last_exp = '0; last_int = '0;

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 pc_out", pc_out, 32'h0);
    check("R12 sr_out", sr_out, 32'h0);
    check("R12 spc", spc, 32'h0);
    check("R12 flags", {29'h0, done, taken_exc, taken_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 done after reset", {31'h0, done}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      fire(VECS[i]);
      if (VECS[i].kind == 2'd1) begin
        last_ssr = VECS[i].sr; last_exp = VECS[i].e_evt;
      end else if (VECS[i].kind == 2'd2) begin
        last_ssr = VECS[i].sr; last_int = VECS[i].e_evt;
      end
      check($sformatf("R8 R7 R10 pc_out v%0d", i), pc_out, VECS[i].e_pc);
      check($sformatf("R6 R9 spc v%0d", i), spc, VECS[i].e_spc);
      check($sformatf("R5 R7 sr_out v%0d", i), sr_out, VECS[i].e_sr);
      check($sformatf("R6 ds_out v%0d", i), {28'h0, ds_out}, {28'h0, VECS[i].e_ds});
      check($sformatf("R5 ssr v%0d", i), ssr, last_ssr);
      check($sformatf("R5 sgr v%0d", i), sgr, R15);
      check($sformatf("R2 R10 expevt v%0d", i), {20'h0, expevt}, {20'h0, last_exp});
      check($sformatf("R1 R10 intevt v%0d", i), {20'h0, intevt}, {20'h0, last_int});
      check($sformatf("R1 R3 R4 kind v%0d", i), {29'h0, done, taken_exc, taken_irq},
            {29'h0, 1'b1, VECS[i].kind == 2'd1, VECS[i].kind == 2'd2});
    end

    // R11: done and taken flags drop one cycle later; no change without strobe
    exc_code = 12'h040; pc_in = 32'h0C00_7000; sr_in = 32'h0;
    @(negedge clk);
    check("R11 done pulse width", {30'h0, done, taken_exc}, 32'h0);
    check("R11 pc held without strobe", pc_out, 32'h8C00_0100);
    check("R11 spc held without strobe", spc, 32'h0C00_1000);

    // R12: reset again clears all state
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 pc_out after reset", pc_out, 32'h0);
    check("R12 expevt after reset", {20'h0, expevt}, 32'h0);
    rst_n = 1'b1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule